// File: doc/BRIEF.md
# Tuner Synthesiser Serial Register Interface

This block is the I2C slave front end of a tuning frequency synthesiser. It runs on a fast system clock and oversamples the bus clock and data lines. SDA is modelled as an open-drain output: the block asserts an enable to pull the line low. The seven-bit slave address is a fixed five-bit prefix followed by two bits taken from a pin-strapped select input. Up to four synthesisers can therefore share one bus.

In a write transfer, data bytes arrive in pairs. The top bit of the first byte of each pair picks the destination:
- A 0 starts a divide-ratio pair. The 15-bit ratio is handed to the divider in one step once the pair is complete, with a one-cycle update strobe.
- A 1 starts a control pair. It sets seven loop-control bits and then four port enables.

A read transfer returns a status byte. The status byte holds a power-on flag, the lock flag, three port input levels and a three-bit converter code. It is repeated for as long as the master acknowledges.

A power-on or low-supply event sets the power-on flag and wipes every programmed value. The flag stays set until a transfer that included a read is closed by a STOP.

Top module: `tuner_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {5'b11000, addr_sel[1:0]}; bit 0 is 0 for write and 1 for read. A transfer to any other address leaves every output register unchanged and SDA released.
- R2: The block pulls SDA low for the whole acknowledge clock after a matching address and after every data byte of a write. It changes its SDA drive only after a falling SCL edge, or on START or STOP.
- R3: A pair whose first byte has bit 7 = 0 loads ratio_o = {first[6:0], second[7:0]}. ratio_o changes only when the second byte is complete, and ratio_upd pulses exactly once for each completed pair.
- R4: A pair whose first byte has bit 7 = 1 loads ctrl_o = first[6:0] when the first byte completes. The second byte then loads port_on_o = second[7:4], with bit 3 = P7 down to bit 0 = P4. second[3:0] is ignored.
- R5: Any number of pairs may follow one address without re-addressing. The lead bit of each pair selects its destination independently of the pairs before it.
- R6: A transfer cut off by STOP or START part way through a byte, or between the two bytes of a ratio pair, leaves ratio_o unchanged. The next transfer starts a fresh pair.
- R7: The read status byte is {por_o, lock_i, port_in[2:0], adc_code[2:0]}, sent MSB first. It is sampled when each status byte begins.
- R8: During a read, the block sends another status byte after each master ACK. After a master NACK it releases SDA and ignores clocks until the next START.
- R9: Reset or a por_evt pulse sets por_o and clears ratio_o, ctrl_o and port_on_o to zero.
- R10: por_o is cleared by a STOP that ends a transfer in which a read address was acknowledged. A STOP ending a write-only transfer leaves por_o set.
- R11: A repeated START abandons the current transfer and restarts address matching, including a switch from write to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset, acts as power-on |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Pin-strapped low address bits |
| por_evt | input | 1 | Power-on or low-supply event pulse |
| lock_i | input | 1 | Loop lock indication |
| port_in | input | 3 | Port levels P7, P5, P4 (bit 2 down to 0) |
| adc_code | input | 3 | Converter code |
| ratio_o | output | 15 | Divide ratio to the synthesiser |
| ratio_upd | output | 1 | One-cycle pulse when ratio_o is loaded |
| ctrl_o | output | 7 | Loop control bits, bit 6 first received |
| port_on_o | output | 4 | Port drive enables P7..P4 |
| por_o | output | 1 | Power-on flag |

## Verification
The bench builds the block with the default five-bit prefix 5'b11000 and two synchroniser stages. It uses an SCL phase of six system clocks, which stays above the four-clock sense-and-react latency. This keeps acknowledge and read-bit timing tight while staying legal. Random transfers change addr_sel between transfers, so all four address codes are covered, both as matches and as near-miss addresses. Directed cases cover aborted bytes, a half-sent ratio pair, a repeated START switching from write to read, and clearing of the power-on flag.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int ADDR_W  = 7;
  localparam int RATIO_W = 15;
  localparam int CTRL_W  = 7;
  localparam int PORT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
  } bus_state_e;

  function automatic logic [ADDR_W-1:0] own_address(input logic [4:0] prefix,
                                                    input logic [1:0] sel);
    return {prefix, sel};
  endfunction

  function automatic logic [RATIO_W-1:0] join_ratio(input logic [6:0] hi,
                                                    input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [7:0] pack_status(input logic por, input logic lock,
                                             input logic [2:0] pins,
                                             input logic [2:0] adc);
    return {por, lock, pins, adc};
  endfunction
endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tuner_i2c_engine.sv
module tuner_i2c_engine
  import tuner_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [7:0]        status,
  output logic              sda_oe,
  output logic              wr_begin,
  output logic              byte_stb,
  output logic [7:0]        byte_val,
  output logic              read_stop
);
  bus_state_e st;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic [7:0] sh_next;
  logic       full, rw, mack, rd_seen;

  assign sh_next = {sh[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; full <= 1'b0; rw <= 1'b0;
      mack <= 1'b0; rd_seen <= 1'b0; sda_oe <= 1'b0;
      wr_begin <= 1'b0; byte_stb <= 1'b0; byte_val <= '0; read_stop <= 1'b0;
    end else begin
      wr_begin  <= 1'b0;
      byte_stb  <= 1'b0;
      read_stop <= 1'b0;
      if (stop_evt) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
        read_stop <= rd_seen; rd_seen <= 1'b0;
      end else if (start_evt) begin
        st <= ST_ADDR; cnt <= '0; full <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && !full) begin
              sh  <= sh_next;
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                full <= 1'b1;
                if (st == ST_WDATA) begin
                  byte_stb <= 1'b1;
                  byte_val <= sh_next;
                end
              end
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == own_addr) begin
                  st <= ST_ACK; sda_oe <= 1'b1; rw <= sh[0];
                  if (sh[0]) rd_seen <= 1'b1;
                  else       wr_begin <= 1'b1;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st <= ST_ACK; sda_oe <= 1'b1;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= ST_RDATA; sh <= status; sda_oe <= ~status[7];
            end else begin
              st <= ST_WDATA; sda_oe <= 1'b0;
            end
          end
          ST_RDATA: if (scl_fall) begin
            if (cnt == 3'd7) begin
              st <= ST_RACK; sda_oe <= 1'b0;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 3'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                st <= ST_RDATA; sh <= status; sda_oe <= ~status[7]; cnt <= '0;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));
  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R1
  begin_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_begin |-> (sda_oe && st == ST_ACK));
endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
  import tuner_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_evt,
  input  logic               wr_begin,
  input  logic               byte_stb,
  input  logic [7:0]         byte_val,
  input  logic               read_stop,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               ratio_upd,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [PORT_W-1:0]  port_q,
  output logic               por_q
);
  logic       second, pair_ctrl;
  logic [6:0] hi_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0; ratio_upd <= 1'b0; ctrl_q <= '0; port_q <= '0; por_q <= 1'b1;
      second <= 1'b0; pair_ctrl <= 1'b0; hi_hold <= '0;
    end else if (por_evt) begin
      ratio_q <= '0; ratio_upd <= 1'b0; ctrl_q <= '0; port_q <= '0; por_q <= 1'b1;
      second <= 1'b0; pair_ctrl <= 1'b0; hi_hold <= '0;
    end else begin
      ratio_upd <= 1'b0;
      if (read_stop) por_q <= 1'b0;
      if (wr_begin) begin
        second <= 1'b0;
      end else if (byte_stb) begin
        if (!second) begin
          second    <= 1'b1;
          pair_ctrl <= byte_val[7];
          if (byte_val[7]) ctrl_q  <= byte_val[6:0];
          else             hi_hold <= byte_val[6:0];
        end else begin
          second <= 1'b0;
          if (pair_ctrl) begin
            port_q <= byte_val[7:4];
          end else begin
            ratio_q   <= join_ratio(hi_hold, byte_val);
            ratio_upd <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> ($past(byte_stb) || $past(por_evt)));
  // R4
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_q) |-> ($past(byte_stb) || $past(por_evt)));
  // R9
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (por_q && ratio_q == '0 && ctrl_q == '0 && port_q == '0));
  // R10
  por_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(read_stop));
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tuner_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [1:0]         addr_sel,
  input  logic               por_evt,
  input  logic               lock_i,
  input  logic [2:0]         port_in,
  input  logic [2:0]         adc_code,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               ratio_upd,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [PORT_W-1:0]  port_on_o,
  output logic               por_o
);
  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_begin, byte_stb, read_stop;
  logic [7:0] byte_val, status;

  assign status = pack_status(por_o, lock_i, port_in, adc_code);

  tuner_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  tuner_i2c_engine u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .own_addr(own_address(ADDR_PREFIX, addr_sel)), .status(status),
    .sda_oe(sda_oe), .wr_begin(wr_begin), .byte_stb(byte_stb),
    .byte_val(byte_val), .read_stop(read_stop)
  );

  tuner_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .wr_begin(wr_begin),
    .byte_stb(byte_stb), .byte_val(byte_val), .read_stop(read_stop),
    .ratio_q(ratio_o), .ratio_upd(ratio_upd), .ctrl_q(ctrl_o),
    .port_q(port_on_o), .por_q(por_o)
  );
endmodule

// File: tb/tuner_i2c_slave_tb.sv
module tuner_i2c_slave_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_bus;
  logic [1:0] addr_sel = 2'd0;
  logic por_evt = 1'b0, lock_i = 1'b0;
  logic [2:0] port_in = 3'd0, adc_code = 3'd0;
  logic [14:0] ratio_o;
  logic ratio_upd;
  logic [6:0] ctrl_o;
  logic [3:0] port_on_o;
  logic por_o;

  int n_tests = 0, n_fail = 0, upd_cnt = 0;
  bit done = 0;
  int e_ratio = 0, e_ctrl = 0, e_port = 0;

  always #4 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  tuner_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .por_evt(por_evt), .lock_i(lock_i), .port_in(port_in),
    .adc_code(adc_code), .ratio_o(ratio_o), .ratio_upd(ratio_upd),
    .ctrl_o(ctrl_o), .port_on_o(port_on_o), .por_o(por_o)
  );

  always @(posedge clk) if (ratio_upd) upd_cnt <= upd_cnt + 1;

  function automatic int exp_ratio(input int b2, input int b3);
    return (b2 % 128) * 256 + b3;
  endfunction
  function automatic int exp_status(input int por, input int lk, input int pins, input int adc);
    return por * 128 + lk * 64 + pins * 8 + adc;
  endfunction
  function automatic logic [7:0] addr_byte(input int sel, input int rd);
    return 8'(8'hC0 + sel * 2 + rd);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
  task automatic i2c_stop(); m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); wq(); endtask
  task automatic put_bit(input logic b); m_sda = b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq(); endtask
  task automatic get_bit(output logic b); m_sda = 1; wq(); m_scl = 1; wq(); b = sda_bus; wq(); m_scl = 0; wq(); endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~give_ack);
  endtask

  task automatic model_pair(input int b1, input int b2);
    if (b1 >= 128) begin e_ctrl = b1 % 128; e_port = b2 / 16; end
    else e_ratio = exp_ratio(b1, b2);
  endtask

  task automatic chk_regs(input string req);
    chk(req, "ratio", int'(ratio_o), e_ratio);
    chk(req, "ctrl", int'(ctrl_o), e_ctrl);
    chk(req, "ports", int'(port_on_o), e_port);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] rv;
    int seed, u0, zeros;
    seed = 7;
    u0 = $urandom(seed);
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset ratio", int'(ratio_o), 0);
    chk("R9", "reset ctrl", int'(ctrl_o), 0);
    chk("R9", "reset ports", int'(port_on_o), 0);
    chk("R9", "reset por", int'(por_o), 1);
    chk("R2", "reset sda_oe", int'(sda_oe), 0);

    // R1 wrong address ignored
    addr_sel = 2'd2;
    i2c_start(); send_byte(addr_byte(1, 0), a0); send_byte(8'h12, a1); send_byte(8'h34, a2); i2c_stop();
    chk("R1", "nack wrong addr", int'(a0), 0);
    chk("R1", "no ack data to other", int'(a1 | a2), 0);
    chk_regs("R1");

    // R2 R3 ratio pair, atomic
    i2c_start(); send_byte(addr_byte(2, 0), a0); send_byte(8'h55, a1);
    chk("R3", "ratio held after first byte", int'(ratio_o), 0);
    send_byte(8'hAA, a2); i2c_stop();
    chk("R2", "acks addr/data", int'({a0, a1, a2}), 7);
    model_pair(8'h55, 8'hAA); chk_regs("R3");
    chk("R3", "one update pulse", upd_cnt, 1);

    // R4 control pair
    i2c_start(); send_byte(addr_byte(2, 0), a0); send_byte(8'hC5, a1);
    chk("R4", "ctrl on first byte", int'(ctrl_o), 8'h45);
    send_byte(8'hA3, a2); i2c_stop();
    model_pair(8'hC5, 8'hA3); chk_regs("R4");

    // R5 several pairs in one transfer
    i2c_start(); send_byte(addr_byte(2, 0), a0);
    send_byte(8'h12, a1); send_byte(8'h34, a1); model_pair(8'h12, 8'h34);
    send_byte(8'hFF, a1); send_byte(8'h5F, a1); model_pair(8'hFF, 8'h5F);
    send_byte(8'h7F, a1); send_byte(8'hFF, a3); model_pair(8'h7F, 8'hFF);
    i2c_stop();
    chk("R5", "last ack", int'(a3), 1);
    chk_regs("R5");
    chk("R5", "update pulses", upd_cnt, 3);

    // R6 half pair then abort, and mid-byte abort
    i2c_start(); send_byte(addr_byte(2, 0), a0); send_byte(8'h03, a1); i2c_stop();
    chk_regs("R6");
    i2c_start(); send_byte(addr_byte(2, 0), a0); put_bit(1); put_bit(0); put_bit(1); put_bit(1); i2c_stop();
    chk_regs("R6");
    i2c_start(); send_byte(addr_byte(2, 0), a0); send_byte(8'h81, a1); send_byte(8'h30, a2); i2c_stop();
    model_pair(8'h81, 8'h30); chk_regs("R6");

    // R7 R8 read with continuation, NACK, then idle clocks
    lock_i = 1; port_in = 3'b101; adc_code = 3'b011;
    i2c_start(); send_byte(addr_byte(2, 1), a0);
    chk("R1", "read address ack", int'(a0), 1);
    recv_byte(rv, 1'b1);
    chk("R7", "status first", int'(rv), exp_status(1, 1, 5, 3));
    recv_byte(rv, 1'b0);
    chk("R8", "status repeated", int'(rv), exp_status(1, 1, 5, 3));
    zeros = 0;
    for (int i = 0; i < 9; i++) begin get_bit(a1); if (!a1) zeros++; end
    chk("R8", "released after nack", zeros, 0);
    chk("R10", "por held until stop", int'(por_o), 1);
    i2c_stop();
    chk("R10", "por cleared by read stop", int'(por_o), 0);
    lock_i = 0; port_in = 3'b010; adc_code = 3'b100;
    i2c_start(); send_byte(addr_byte(2, 1), a0); recv_byte(rv, 1'b0); i2c_stop();
    chk("R7", "status second pattern", int'(rv), exp_status(0, 0, 2, 4));

    // R9 event, R10 write-only stop keeps flag
    @(negedge clk); por_evt = 1; @(negedge clk); por_evt = 0; @(negedge clk);
    e_ratio = 0; e_ctrl = 0; e_port = 0;
    chk_regs("R9");
    chk("R9", "por after event", int'(por_o), 1);
    i2c_start(); send_byte(addr_byte(2, 0), a0); send_byte(8'h01, a1); send_byte(8'h02, a2); i2c_stop();
    model_pair(8'h01, 8'h02); chk_regs("R10");
    chk("R10", "write stop keeps por", int'(por_o), 1);

    // R11 repeated start write -> read
    i2c_start(); send_byte(addr_byte(2, 0), a0); send_byte(8'h05, a1);
    i2c_start(); send_byte(addr_byte(2, 1), a2); recv_byte(rv, 1'b0); i2c_stop();
    chk("R11", "read after restart ack", int'(a2), 1);
    chk("R11", "status after restart", int'(rv), exp_status(1, 0, 2, 4));
    chk_regs("R6");
    chk("R11", "por cleared", int'(por_o), 0);
    i2c_start(); send_byte(addr_byte(0, 0), a0); i2c_start(); send_byte(addr_byte(2, 0), a1);
    send_byte(8'h6B, a2); send_byte(8'h9C, a3); i2c_stop();
    model_pair(8'h6B, 8'h9C);
    chk("R11", "acks other/own", int'({a0, a1}), 1);
    chk_regs("R11");

    // random transfers
    for (int t = 0; t < 30; t++) begin
      int sel, tsel, b1, b2;
      logic hit;
      sel = $urandom % 4;
      tsel = ($urandom % 4 == 0) ? (sel ^ (1 + $urandom % 3)) : sel;
      b1 = $urandom % 256; b2 = $urandom % 256;
      addr_sel = 2'(sel);
      hit = (tsel == sel);
      i2c_start(); send_byte(addr_byte(tsel, 0), a0); send_byte(8'(b1), a1); send_byte(8'(b2), a2); i2c_stop();
      if (hit) model_pair(b1, b2);
      chk("R1", "random address ack", int'(a0), int'(hit));
      chk_regs(b1 >= 128 ? "R4" : "R3");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule